// File: doc/BRIEF.md
# Polled Transmit Descriptor Engine

This block moves outgoing frames from memory to a byte-wide transmit stream under the control of descriptors that software places in memory. Each descriptor has four 32-bit words. Word 0 is the status word, and its bit 31 is the ownership flag. Word 1 is the control word. Word 2 is the buffer word address. Word 3 is the link to the next descriptor. The engine stays idle until software writes the poll strobe while the run control is set. It then reads the current descriptor. If it owns that descriptor, it streams the buffer and writes the status back with the ownership flag cleared. It then moves on to the next descriptor by itself, and stops when it meets one it does not own.

The buffer is read a whole word at a time. Each word goes out lowest byte first. The downstream side applies back-pressure with a ready signal. If one byte is held back for too long, the engine gives up on the frame and writes back an error status instead of a clean one.

The engine runs through seven named states:
- IDLE waits for a poll.
- FETCH reads the four descriptor words.
- CHECK tests ownership and the byte count.
- LOAD and LATCH read one buffer word.
- SEND offers bytes.
- WBACK writes the status and steps the descriptor pointer.

The transitions are:
- IDLE to FETCH on a poll while running.
- FETCH to CHECK after the fourth word.
- CHECK goes to IDLE if the descriptor is not owned, to WBACK if the count is zero, and to LOAD otherwise.
- LOAD to LATCH to SEND.
- SEND goes back to LOAD when a word is used up. It goes to WBACK on the last byte or on a stall timeout.
- WBACK goes to FETCH while running, and to IDLE otherwise.

Top module: `tdma_tx_engine`

## Requirements
- R1: After reset the engine is idle: `tx_valid`, `tx_sof`, `tx_eof` and `mem_en` are all low until a poll arrives.
- R2: A one-cycle `poll_wr` pulse while `tx_start` is high makes the engine read descriptor words 0 to 3 at word addresses P to P+3, where P is the current descriptor pointer. A poll while `tx_start` is low causes no memory access.
- R3: If status bit 31 of the fetched descriptor is 0, the engine sends no bytes, writes nothing and returns to idle.
- R4: For an owned descriptor, the engine delivers exactly control[10:0] bytes. They are read from consecutive words starting at the word address in word 2, and byte lane 0 (bits 7:0) of each word goes out first.
- R5: `tx_sof` is high with the first byte only when control bit 29 is set. `tx_eof` is high with the last byte only when control bit 30 is set.
- R6: When a frame finishes normally, the engine writes 32'h0000_0000 to word 0 of the descriptor. This clears bit 31, the error bits 15 and 1, and the collision count in bits 6:3.
- R7: The next descriptor pointer is `ring_base` if control bit 25 is set. Otherwise it is word 3 if control bit 24 is set. Otherwise it is the current pointer plus 4.
- R8: After a write-back, if `tx_start` is still high, the engine fetches the next descriptor without waiting for another poll.
- R9: While `tx_valid` is high and `tx_ready` is low, the offered byte and its markers hold steady.
- R10: One byte may be stalled for up to STALL_LIMIT consecutive cycles without effect. On the next stalled cycle the frame is aborted: no further bytes are sent, and 32'h0000_8002 is written to word 0 (bit 15 error summary, bit 1 underflow, bit 31 clear).
- R11: A descriptor with a byte count of zero is written back as complete (32'h0) with no bytes sent.
- R12: A rising edge on `tx_start` while idle loads the pointer from `ring_base`. Lowering `tx_start` lets the current frame finish, and the engine then goes idle without fetching again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ring_base | input | AW | Ring base word address |
| tx_start | input | 1 | Run control |
| poll_wr | input | 1 | Poll demand strobe |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read |
| tx_valid | output | 1 | Byte offered |
| tx_ready | input | 1 | Downstream accepts byte |
| tx_data | output | 8 | Byte value |
| tx_sof | output | 1 | First byte of frame |
| tx_eof | output | 1 | Last byte of frame |

## Verification
On every cycle, the assertions check four things:
- a held byte stays stable while stalled;
- each write-back clears ownership and keeps its two error bits consistent;
- a timeout is followed at once by an error write-back;
- nothing is fetched after a stop or after an unowned descriptor.

Only the bench scenarios can show that the right bytes arrive in the right order, that the markers follow the control bits, and that the pointer steps correctly. Those scenarios include the pointer's wrap, link and linear steps, as well as the exact boundary between a tolerated stall and an abort.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CHECK, S_LOAD, S_LATCH, S_SEND, S_WBACK
    } tdma_state_e;

    localparam int DESC_WORDS = 4;
    localparam int LEN_W      = 11;
    localparam int OWN_BIT    = 31;
    localparam int ERR_SUM    = 15;
    localparam int ERR_UNDER  = 1;
    localparam int CTL_LS     = 30;
    localparam int CTL_FS     = 29;
    localparam int CTL_EOR    = 25;
    localparam int CTL_CHAIN  = 24;
endpackage

// File: rtl/tdma_next_ptr.sv
module tdma_next_ptr #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] ring_base,
    input  logic          eor,
    input  logic          chain,
    input  logic [AW-1:0] link,
    output logic [AW-1:0] nxt
);
    import tdma_pkg::*;

    always_comb begin
        if (eor)        nxt = ring_base;
        else if (chain) nxt = link;
        else            nxt = cur + AW'(DESC_WORDS);
    end
endmodule

// File: rtl/tdma_stall_timer.sv
module tdma_stall_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!active) cnt_q <= '0;
        else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
    end

    assign hit = active && (cnt_q == CW'(LIMIT));

    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= CW'(LIMIT)));
endmodule

// File: rtl/tdma_tx_engine.sv
module tdma_tx_engine #(
    parameter int AW          = 16,
    parameter int STALL_LIMIT = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base,
    input  logic          tx_start,
    input  logic          poll_wr,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    output logic          tx_sof,
    output logic          tx_eof
);
    import tdma_pkg::*;

    tdma_state_e state_q, state_d;

    logic [2:0]       fcnt_q;
    logic [31:0]      stat_q, ctrl_q, bufp_q, link_q, word_q;
    logic [AW-1:0]    cur_q, widx_q, nxt_ptr;
    logic [1:0]       bidx_q;
    logic [LEN_W-1:0] left_q;
    logic             first_q, err_q, start_q;
    logic             fire, stall_hit;
    logic             unused_desc;

    assign unused_desc = ^{stat_q[30:0], ctrl_q[31], ctrl_q[28:26], ctrl_q[23:11],
                           bufp_q[31:AW], link_q[31:AW]};

    tdma_next_ptr #(.AW(AW)) u_next (
        .cur       (cur_q),
        .ring_base (ring_base),
        .eor       (ctrl_q[CTL_EOR]),
        .chain     (ctrl_q[CTL_CHAIN]),
        .link      (link_q[AW-1:0]),
        .nxt       (nxt_ptr)
    );

    tdma_stall_timer #(.LIMIT(STALL_LIMIT)) u_stall (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (tx_valid && !tx_ready),
        .hit    (stall_hit)
    );

    assign fire = tx_valid && tx_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (poll_wr && tx_start) state_d = S_FETCH;
            S_FETCH: if (fcnt_q == 3'd4) state_d = S_CHECK;
            S_CHECK: begin
                if (!stat_q[OWN_BIT])                state_d = S_IDLE;
                else if (ctrl_q[LEN_W-1:0] == '0)    state_d = S_WBACK;
                else                                 state_d = S_LOAD;
            end
            S_LOAD:  state_d = S_LATCH;
            S_LATCH: state_d = S_SEND;
            S_SEND: begin
                if (stall_hit)                 state_d = S_WBACK;
                else if (fire && left_q == 1)  state_d = S_WBACK;
                else if (fire && bidx_q == 2'd3) state_d = S_LOAD;
            end
            S_WBACK: state_d = tx_start ? S_FETCH : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcnt_q  <= '0;
            stat_q  <= '0;
            ctrl_q  <= '0;
            bufp_q  <= '0;
            link_q  <= '0;
            word_q  <= '0;
            cur_q   <= '0;
            widx_q  <= '0;
            bidx_q  <= '0;
            left_q  <= '0;
            first_q <= 1'b0;
            err_q   <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= tx_start;
            unique case (state_q)
                S_IDLE: begin
                    fcnt_q <= '0;
                    if (tx_start && !start_q) cur_q <= ring_base;
                end
                S_FETCH: begin
                    fcnt_q <= fcnt_q + 1'b1;
                    case (fcnt_q)
                        3'd1: stat_q <= mem_rdata;
                        3'd2: ctrl_q <= mem_rdata;
                        3'd3: bufp_q <= mem_rdata;
                        3'd4: link_q <= mem_rdata;
                        default: ;
                    endcase
                end
                S_CHECK: begin
                    left_q  <= ctrl_q[LEN_W-1:0];
                    widx_q  <= '0;
                    bidx_q  <= '0;
                    first_q <= 1'b1;
                    err_q   <= 1'b0;
                end
                S_LOAD: ;
                S_LATCH: word_q <= mem_rdata;
                S_SEND: begin
                    if (stall_hit) begin
                        err_q <= 1'b1;
                    end else if (fire) begin
                        left_q  <= left_q - 1'b1;
                        bidx_q  <= bidx_q + 1'b1;
                        first_q <= 1'b0;
                        if (bidx_q == 2'd3) widx_q <= widx_q + 1'b1;
                    end
                end
                S_WBACK: begin
                    cur_q  <= nxt_ptr;
                    fcnt_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = '0;
        tx_valid  = 1'b0;
        tx_sof    = 1'b0;
        tx_eof    = 1'b0;
        tx_data   = word_q[8*bidx_q +: 8];
        unique case (state_q)
            S_FETCH: begin
                mem_en   = (fcnt_q < 3'd4);
                mem_addr = cur_q + AW'(fcnt_q);
            end
            S_LOAD: begin
                mem_en   = 1'b1;
                mem_addr = bufp_q[AW-1:0] + widx_q;
            end
            S_SEND: begin
                tx_valid = 1'b1;
                tx_sof   = first_q && ctrl_q[CTL_FS];
                tx_eof   = (left_q == 1) && ctrl_q[CTL_LS];
            end
            S_WBACK: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_wdata[ERR_SUM]   = err_q;
                mem_wdata[ERR_UNDER] = err_q;
            end
            default: ;
        endcase
    end

    p_quiet_unowned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && !stat_q[OWN_BIT]) |=> !mem_en && !tx_valid);
    p_marks_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sof || tx_eof) |-> tx_valid);
    p_wb_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> !mem_wdata[OWN_BIT] && (mem_wdata[ERR_SUM] == mem_wdata[ERR_UNDER]));
    p_hold_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !stall_hit) |=> tx_valid && $stable(tx_data) && $stable(tx_sof));
    p_abort_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stall_hit |=> mem_en && mem_we && mem_wdata[ERR_SUM]);
    p_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && !tx_start) |=> !mem_en);
endmodule

// File: tb/tb_tdma_tx_engine.sv
module tb_tdma_tx_engine;
    localparam int AW = 8;
    localparam int LIM = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ring_base = 8'd16;
    logic          tx_start = 1'b0;
    logic          poll_wr = 1'b0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          tx_valid;
    logic          tx_ready = 1'b0;
    logic [7:0]    tx_data;
    logic          tx_sof, tx_eof;

    tdma_tx_engine #(.AW(AW), .STALL_LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .tx_start(tx_start),
        .poll_wr(poll_wr), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof)
    );

    always #5 clk = ~clk;

    logic [31:0] mem [256];
    always @(posedge clk) begin
        if (mem_en && mem_we)  mem[mem_addr] <= mem_wdata;
        if (mem_en && !mem_we) mem_rdata <= mem[mem_addr];
    end

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int rx_n, sof_cnt, sof_idx, eof_cnt, eof_idx, wr_n, rd_n;
    logic [7:0]  rx_b [64];
    logic [7:0]  wr_a [8];
    logic [31:0] wr_d [8];
    logic [7:0]  nf [8];
    bit          nf_ok [8];
    bit          after_wr;
    int rdy_mode = 0, ph = 0, hold = 0, hold_lim = 0;

    always @(posedge clk) if (rst_n) begin
        if (tx_valid && tx_ready) begin
            if (rx_n < 64) rx_b[rx_n] = tx_data;
            if (tx_sof) begin sof_cnt++; sof_idx = rx_n; end
            if (tx_eof) begin eof_cnt++; eof_idx = rx_n; end
            rx_n++;
        end
        if (mem_en && mem_we) begin
            if (wr_n < 8) begin wr_a[wr_n] = mem_addr; wr_d[wr_n] = mem_wdata; end
            wr_n++;
            after_wr = 1;
        end else if (mem_en) begin
            rd_n++;
            if (after_wr && wr_n <= 8) begin nf[wr_n-1] = mem_addr; nf_ok[wr_n-1] = 1; end
            after_wr = 0;
        end
    end

    always @(negedge clk) begin
        case (rdy_mode)
            0: tx_ready = 1'b1;
            1: tx_ready = ~tx_ready;
            2: begin ph = (ph + 1) % 3; tx_ready = (ph == 0); end
            default: begin
                if (rx_n == 2 && tx_valid) begin tx_ready = (hold >= hold_lim); hold++; end
                else tx_ready = 1'b1;
            end
        endcase
    end

    function automatic logic [7:0] pat(int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_log();
        rx_n = 0; sof_cnt = 0; sof_idx = -1; eof_cnt = 0; eof_idx = -1;
        wr_n = 0; rd_n = 0; after_wr = 0; hold = 0;
        for (int i = 0; i < 8; i++) begin nf_ok[i] = 0; nf[i] = '0; end
    endtask

    task automatic put_desc(input int a, input logic [31:0] ctrl, input int bufw, input int nxt);
        mem[a]   = 32'h8000_0000;
        mem[a+1] = ctrl;
        mem[a+2] = 32'(bufw);
        mem[a+3] = 32'(nxt);
    endtask

    task automatic poll();
        @(negedge clk) poll_wr = 1'b1;
        @(negedge clk) poll_wr = 1'b0;
    endtask

    task automatic check_bytes(input string tag, input int first, input int bufw, input int n);
        int bad = 0;
        for (int i = 0; i < n; i++)
            if (rx_b[first+i] !== pat(bufw*4 + i)) bad++;
        chk(bad == 0, tag, "byte mismatches", bad, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 128; w++) mem[w] = '0;
        for (int w = 128; w < 256; w++)
            for (int b = 0; b < 4; b++) mem[w][8*b +: 8] = pat(w*4 + b);
        clear_log();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!tx_valid && !tx_sof && !tx_eof, "R1", "stream idle", tx_valid, 0);
        chk(!mem_en, "R1", "memory idle", mem_en, 0);

        // R2 poll ignored while not running
        put_desc(16, 32'h6200_0004, 130, 0);
        clear_log(); poll(); repeat (20) @(negedge clk);
        chk(rd_n == 0, "R2", "reads while stopped", rd_n, 0);
        chk(rx_n == 0, "R2", "bytes while stopped", rx_n, 0);

        // R12 reload from base, R2 fetch
        ring_base = 8'd16; tx_start = 1'b1; @(negedge clk);
        clear_log(); poll(); repeat (60) @(negedge clk);
        chk(rx_n == 4, "R2", "bytes after poll", rx_n, 4);
        chk(wr_n == 1 && wr_a[0] == 16, "R12", "writeback at base", wr_a[0], 16);
        check_bytes("R4", 0, 130, 4);

        // R3 unowned descriptor
        clear_log(); poll(); repeat (20) @(negedge clk);
        chk(rd_n == 4, "R3", "descriptor reads", rd_n, 4);
        chk(wr_n == 0, "R3", "writes", wr_n, 0);
        chk(rx_n == 0, "R3", "bytes", rx_n, 0);

        // Sweep of length, markers and back-pressure pattern
        for (int len = 0; len < 10; len++) begin
            for (int fl = 0; fl < 4; fl++) begin
                bit es, ee;
                rdy_mode = (len + fl) % 3;
                put_desc(16, 32'h0200_0000 | (32'(fl & 1) << 29) | (32'(fl >> 1) << 30) | 32'(len),
                         160 + len, 0);
                clear_log(); poll(); repeat (100) @(negedge clk);
                chk(rx_n == len, "R4", "byte count", rx_n, len);
                if (len > 0) check_bytes("R4", 0, 160 + len, len);
                es = (fl & 1) && len > 0;
                ee = (fl >> 1) && len > 0;
                chk(sof_cnt == int'(es), "R5", "sof count", sof_cnt, es);
                if (es) chk(sof_idx == 0, "R5", "sof position", sof_idx, 0);
                chk(eof_cnt == int'(ee), "R5", "eof count", eof_cnt, ee);
                if (ee) chk(eof_idx == len - 1, "R5", "eof position", eof_idx, len - 1);
                if (len == 0) chk(wr_n == 1 && wr_d[0] == 0, "R11", "empty frame status", wr_d[0], 0);
                else chk(wr_n == 1 && wr_d[0] == 0, "R6", "done status", wr_d[0], 0);
                chk(nf_ok[0] && nf[0] == 16, "R7", "wrap to base", nf[0], 16);
            end
        end

        // R7 / R8 linear, linked and wrapping steps in one run
        rdy_mode = 0;
        put_desc(16, 32'h0000_0003, 170, 0);
        put_desc(20, 32'h0100_0002, 180, 40);
        put_desc(40, 32'h0200_0001, 190, 0);
        clear_log(); poll(); repeat (150) @(negedge clk);
        chk(wr_n == 3, "R8", "descriptors completed", wr_n, 3);
        chk(wr_a[0] == 16 && wr_a[1] == 20 && wr_a[2] == 40, "R8", "writeback order", wr_a[2], 40);
        chk(nf[0] == 20, "R7", "linear step", nf[0], 20);
        chk(nf[1] == 40, "R7", "linked step", nf[1], 40);
        chk(nf[2] == 16, "R7", "ring wrap", nf[2], 16);
        chk(rx_n == 6, "R8", "total bytes", rx_n, 6);
        check_bytes("R8", 0, 170, 3);
        check_bytes("R8", 3, 180, 2);
        check_bytes("R8", 5, 190, 1);

        // R9 / R10 stall right at the limit: tolerated
        rdy_mode = 3; hold_lim = LIM;
        put_desc(16, 32'h6200_0008, 200, 0);
        clear_log(); poll(); repeat (100) @(negedge clk);
        chk(rx_n == 8, "R10", "bytes after tolerated stall", rx_n, 8);
        check_bytes("R9", 0, 200, 8);
        chk(wr_n == 1 && wr_d[0] == 0, "R10", "status after tolerated stall", wr_d[0], 0);

        // R10 one cycle beyond the limit: abort
        hold_lim = LIM + 1;
        put_desc(16, 32'h6200_0008, 200, 0);
        clear_log(); poll(); repeat (100) @(negedge clk);
        chk(rx_n == 2, "R10", "bytes before abort", rx_n, 2);
        chk(wr_n == 1 && wr_d[0] == 32'h0000_8002, "R10", "abort status", wr_d[0], 32'h8002);
        chk(nf[0] == 16, "R10", "continues after abort", nf[0], 16);
        chk(eof_cnt == 0, "R10", "no eof on abort", eof_cnt, 0);

        // R12 stop mid-frame, then restart from a new base
        rdy_mode = 1;
        put_desc(16, 32'h0000_0006, 140, 0);
        put_desc(20, 32'h0200_0002, 150, 0);
        clear_log(); poll(); repeat (8) @(negedge clk);
        tx_start = 1'b0;
        repeat (60) @(negedge clk);
        chk(rx_n == 6, "R12", "frame finished after stop", rx_n, 6);
        chk(wr_n == 1 && !nf_ok[0], "R12", "no fetch after stop", nf_ok[0], 0);
        ring_base = 8'd20; tx_start = 1'b1; @(negedge clk);
        clear_log(); poll(); repeat (40) @(negedge clk);
        chk(rx_n == 2, "R12", "bytes from new base", rx_n, 2);
        chk(wr_n >= 1 && wr_a[0] == 20, "R12", "fetch at new base", wr_a[0], 20);
        check_bytes("R12", 0, 150, 2);
        chk(nf[0] == 20, "R7", "wrap to new base", nf[0], 20);

        done = 1;
        summary();
        $finish;
    end
endmodule